// File: doc/BRIEF.md
# Receive Interrupt Status Collector

This block gathers single-cycle event pulses from the receive path (HDLC message handling and multiframe alignment) into a sticky 8-bit status byte. A processor reads the byte through a simple read strobe. The read returns the byte and clears the bits it returned in the same access. A per-bit mask register decides which stored bits may drive the active-high interrupt line.

A global visibility control sets what happens to masked events. With visibility off, a masked event is dropped. With visibility on, a masked event is still recorded in the status byte and can be read back, but it never drives the interrupt line.

The status byte places message end at bit 7, early frame start at bit 6, the 8 ms multiframe search timeout at bit 5 and multiframe begin at bit 4. Bits 3 to 0 are unused and read as zero. A mask bit of 1 masks its event.

Top module: `rx_irq_status`

## Requirements
- R1: After reset the status byte is 0x00, `rd_data_o` is 0x00, `irq_o` is low and all mask bits are 1 (masked).
- R2: A pulse on `evt_i[k]` whose mask bit is 0 sets status bit 4+k at the next clock edge (k=3 message end, k=2 frame start, k=1 multiframe timeout, k=0 multiframe begin). The bit stays set until a read.
- R3: When `rd_i` is high at a clock edge, `rd_data_o` presents the status byte as it was before that edge and holds it until the next read. Every returned bit is cleared at that edge.
- R4: An accepted event that arrives in the same cycle as a read is not part of the returned byte. It remains set afterwards and is returned by the following read.
- R5: With `vis_i` low, an event whose mask bit is 1 is discarded and never appears in the status byte.
- R6: With `vis_i` high, an event whose mask bit is 1 is still latched into the status byte.
- R7: `irq_o` is registered and level-sensitive. After each clock edge it equals the OR of the stored status bits whose mask bit is 0, so a masked status bit never raises it, whatever `vis_i` is.
- R8: `mask_wr_i` loads `mask_wdata_i[7:4]` into the mask at the clock edge, and `mask_wdata_i[3:0]` is ignored. The new mask decides `irq_o` from that same edge on. Events are qualified by the mask held before the edge.
- R9: Bits 3 to 0 of `rd_data_o` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 4 | Event pulses: [3] message end, [2] frame start, [1] multiframe timeout, [0] multiframe begin |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask write data; bits 7..4 used, 1 = masked |
| vis_i | input | 1 | Latch masked events when high |
| rd_i | input | 1 | Status read strobe, clears returned bits |
| rd_data_o | output | 8 | Status byte returned by the last read |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that each event input is a pulse sampled once per clock. A source that holds an event high for several cycles would simply set its bit again after a read, so the assertions check how one cycle maps to the next and make no claim on pulse width. Reset is asserted once at the start, and every other input may change freely from cycle to cycle. The stimulus drives all inputs on the falling edge. It keeps event pulses sparse but allows them to coincide with reads, mask writes and visibility changes, so that the collision and masking cases are reached often.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  localparam int unsigned EVT_W  = 4;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned PAD_W  = DATA_W - EVT_W;

  typedef logic [EVT_W-1:0]  evt_vec_t;
  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/rx_irq_mask_reg.sv
module rx_irq_mask_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_q_o,
  output logic [W-1:0] mask_d_o
);
  logic [W-1:0] mask_q;

  assign mask_d_o = wr_i ? wdata_i : mask_q;
  assign mask_q_o = mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d_o;
  end

  // R8: a write lands in the register at the edge
  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> mask_q == $past(wdata_i));
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/rx_irq_status_bit.sv
module rx_irq_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic masked_i,
  input  logic vis_i,
  input  logic clr_i,
  output logic q_o,
  output logic d_o
);
  logic take;
  logic q;

  assign take = evt_i & (~masked_i | vis_i);
  assign d_o  = (q & ~clr_i) | take;
  assign q_o  = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d_o;
  end

  // R2: unmasked event always lands
  a_r2_unmasked_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !masked_i) |=> q);
  // R2: sticky without a read
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr_i) |=> q);
  // R3: read with no new event clears
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> !q);
  // R4: collision keeps the event
  a_r4_collision_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i && !masked_i) |=> q);
  // R5: masked event dropped when visibility is off
  a_r5_masked_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && masked_i && !vis_i && !q) |=> !q);
  // R6: masked event kept when visibility is on
  a_r6_masked_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && masked_i && vis_i) |=> q);
endmodule

// File: rtl/rx_irq_line.sv
module rx_irq_line #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_d_i,
  input  logic [W-1:0] mask_d_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_d_i & ~mask_d_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/rx_irq_status.sv
module rx_irq_status
  import rx_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  input  logic              vis_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  evt_vec_t mask_q, mask_d;
  evt_vec_t stat_q, stat_d;
  data_t    rdata_q;

  rx_irq_mask_reg #(.W(EVT_W)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (mask_wr_i),
    .wdata_i  (mask_wdata_i[DATA_W-1:PAD_W]),
    .mask_q_o (mask_q),
    .mask_d_o (mask_d)
  );

  for (genvar k = 0; k < EVT_W; k++) begin : g_bit
    rx_irq_status_bit u_bit (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[k]),
      .masked_i (mask_q[k]),
      .vis_i    (vis_i),
      .clr_i    (rd_i),
      .q_o      (stat_q[k]),
      .d_o      (stat_d[k])
    );
  end

  rx_irq_line #(.W(EVT_W)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_d_i (stat_d),
    .mask_d_i   (mask_d),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= {stat_q, {PAD_W{1'b0}}};
  end

  assign rd_data_o = rdata_q;

  // R3: read returns the pre-edge status
  a_r3_read_value: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rd_data_o[DATA_W-1:PAD_W] == $past(stat_q));
  a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rd_data_o));
  // R7: interrupt only from unmasked stored bits
  a_r7_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(stat_q & ~mask_q));
  a_r7_unmasked_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & ~mask_q)) |-> irq_o);
  // R9: padding bits read as zero
  always_comb begin
    if (rst_n) a_r9_pad_zero: assert (rd_data_o[PAD_W-1:0] == '0);
  end
endmodule

// File: tb/test_rx_irq_status.sv
module test_rx_irq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt = '0;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic       vis = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [3:0] m_stat = '0;
  logic [3:0] m_mask = '1;
  logic [7:0] m_rdata = '0;
  logic       m_irq = 1'b0;

  always #2.5 clk = ~clk;

  rx_irq_status i_rx_irq_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .mask_wr_i(mask_wr),
    .mask_wdata_i(mask_wdata), .vis_i(vis), .rd_i(rd),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [3:0] accepted(logic [3:0] e, logic [3:0] m, logic v);
    return e & (~m | {4{v}});
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    logic [3:0] acc;
    @(posedge clk);
    acc = accepted(evt, m_mask, vis);
    if (rd) begin
      m_rdata = {m_stat, 4'h0};
      m_stat  = acc;
    end else begin
      m_stat = m_stat | acc;
    end
    if (mask_wr) m_mask = mask_wdata[7:4];
    m_irq = |(m_stat & ~m_mask);
    @(negedge clk);
    evt = '0; rd = 1'b0; mask_wr = 1'b0;
  endtask

  task automatic check_outs(string req);
    check({req, " rd_data"}, rd_data, m_rdata);
    check({req, " irq"}, irq, m_irq);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: mask all ones -> event with vis=0 dropped
    evt = 4'hF; step();
    rd = 1'b1; step();
    check("R1 masked after reset", rd_data, 8'h00);
    // R8: unmask all, low nibble ignored
    mask_wr = 1'b1; mask_wdata = 8'h0F; step();
    // R2: message end at bit 7
    evt = 4'b1000; step();
    check("R2 irq", irq, 1'b1);
    rd = 1'b1; step();
    check("R2 msg end bit7", rd_data, 8'h80);
    check("R3 cleared irq", irq, 1'b0);
    // R4: collision
    evt = 4'b0001; step();
    rd = 1'b1; evt = 4'b0100; step();
    check("R4 returned", rd_data, 8'h10);
    check("R4 kept irq", irq, 1'b1);
    rd = 1'b1; step();
    check("R4 next read", rd_data, 8'h40);
    // R5 / R6: mask bit 5 only
    mask_wr = 1'b1; mask_wdata = 8'h20; step();
    vis = 1'b0; evt = 4'b0010; step();
    rd = 1'b1; step();
    check("R5 dropped", rd_data, 8'h00);
    vis = 1'b1; evt = 4'b0010; step();
    check("R6 no irq", irq, 1'b0);
    rd = 1'b1; step();
    check("R6 latched", rd_data, 8'h20);
    // R7/R8: stored masked bit, then unmask raises irq at same edge
    evt = 4'b0010; step();
    check("R7 masked silent", irq, 1'b0);
    mask_wr = 1'b1; mask_wdata = 8'h00; step();
    check("R8 unmask raises irq", irq, 1'b1);
    mask_wr = 1'b1; mask_wdata = 8'hF0; step();
    check("R8 remask lowers irq", irq, 1'b0);
    rd = 1'b1; step();
    check("R9 padding", rd_data[3:0], 4'h0);
    // random phase, R3/R7 against model
    for (int i = 0; i < 4000; i++) begin
      evt = 4'($urandom()) & 4'($urandom());
      rd = ($urandom() % 4) == 0;
      mask_wr = ($urandom() % 16) == 0;
      mask_wdata = 8'($urandom());
      if (($urandom() % 32) == 0) vis = ~vis;
      step();
      check_outs("R3_R7 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule